// File: doc/BRIEF.md
# Gigabit Ethernet Auto-Negotiation Controller

This block runs the 1000BASE-X auto-negotiation exchange for a gigabit link. It watches the byte stream from an 8b/10b decoder, with a flag per byte that marks control characters, and assembles the configuration words the link partner sends. It settles on a partner ability word once that word repeats consistently. It then acknowledges and waits one link-timer period before it declares the link negotiated.

The controller computes the 16-bit configuration word the local transmit generator should send. It also reports three things: that negotiation is in progress, that the page has been received, and that negotiation is complete. Management inputs enable the process, restart it, and clear it. A debug input shortens the link timer so simulations finish quickly. Receive errors can be given as two direct flags, or as a 3-bit code that is decoded from three lines.

Top module: `gbe_an_ctrl`

## Requirements
- R1: After rst_n is low, or after main_rst is high at a clock edge, an_done, page_got, an_busy, partner_ability and tx_cfg_word are all zero.
- R2: While an_en is low the controller stays off: an_busy and an_done stay low and tx_cfg_word is zero, whatever it receives.
- R3: With an_en high, the controller first sends configuration word 0 for one link-timer period. It then sends local_ability with bit 14 cleared. an_busy is high through both phases.
- R4: The link-timer period is SHORT_TICKS clocks while dbg_fast_timer is high and LONG_TICKS clocks while it is low. If dbg_fast_timer is raised after SHORT_TICKS clocks of a period have already passed, the period expires at once.
- R5: A configuration word is received as four bytes: 0xBC flagged as control, then a data byte of 0xB5 or 0x42, then the low data byte, then the high data byte.
- R6: Three consecutive received nonzero configuration words that are equal when bit 14 is ignored complete the ability match. partner_ability then holds that word, and tx_cfg_word becomes local_ability with bit 14 (acknowledge) set. Fewer than three do not complete the match.
- R7: After the ability match, a received word with bit 14 set and its other bits equal to partner_ability enters the acknowledge-complete state. page_got is high exactly while the controller is in that state.
- R8: One link-timer period after page_got rises, an_done goes high, while page_got, an_busy and tx_cfg_word go to zero.
- R9: With err_mode_sel high, the code {rx_even_in, rx_cv_in, rx_disp_in} = 3'b100 (coding violation) or 3'b111 (disparity error) marks the byte as errored, and every other code is ignored. A configuration word that contains an errored byte is discarded.
- R10: With err_mode_sel low, rx_cv_in or rx_disp_in high marks the byte as errored, and rx_even_in has no effect.
- R11: When sig_ok is low, the controller returns to the restart phase (tx_cfg_word 0, an_done low) and cannot complete while sig_ok stays low.
- R12: A pulse on an_restart while an_en is high returns the controller to the restart phase and starts a new link-timer period.
- R13: A received all-zero configuration word after the restart phase returns the controller to the restart phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_rst | input | 1 | Synchronous clear of all state, active high |
| an_en | input | 1 | Auto-negotiation enable |
| an_restart | input | 1 | Restart negotiation |
| dbg_fast_timer | input | 1 | Shortens the link timer |
| sig_ok | input | 1 | Receive signal present |
| rx_byte | input | 8 | Decoded receive byte |
| rx_is_k | input | 1 | Byte is a control character |
| err_mode_sel | input | 1 | 1 selects decoded 3-bit error code, 0 selects direct flags |
| rx_even_in | input | 1 | Even line, used in decoded mode only |
| rx_cv_in | input | 1 | Coding-violation line |
| rx_disp_in | input | 1 | Disparity-error line |
| local_ability | input | 16 | Local advertised ability word |
| tx_cfg_word | output | 16 | Configuration word for the transmit generator |
| partner_ability | output | 16 | Captured link-partner ability word |
| an_busy | output | 1 | Negotiation in progress |
| page_got | output | 1 | In acknowledge-complete state |
| an_done | output | 1 | Negotiation complete |

## Verification
The assertions assume that main_rst and rst_n clear every register. They also assume that the error lines are only meaningful in the same cycle as the byte they qualify. The timer property assumes that dbg_fast_timer changes only between whole test phases. The stimulus follows these assumptions: it drives one byte per clock at the falling edge, and it sets the error lines only together with the byte they corrupt. It changes the debug and mode inputs only while the receive stream is quiet, and it waits out each link-timer period completely before it checks the next phase.

// File: rtl/gbe_an_pkg.sv
package gbe_an_pkg;
    typedef enum logic [2:0] {
        ST_OFF, ST_RESTART, ST_ABIL, ST_ACK, ST_CPL, ST_LINK
    } an_state_e;

    typedef enum logic [1:0] {
        PH_HUNT, PH_MARK, PH_LO, PH_HI
    } rx_phase_e;

    localparam logic [7:0] K_COMMA  = 8'hBC;
    localparam logic [7:0] D_MARK_A = 8'hB5;
    localparam logic [7:0] D_MARK_B = 8'h42;
    localparam int         ACK_BIT  = 14;
endpackage

// File: rtl/gbe_an_err_decode.sv
module gbe_an_err_decode (
    input  logic mode_dec,
    input  logic even_in,
    input  logic cv_in,
    input  logic disp_in,
    output logic byte_err
);
    always_comb begin
        if (mode_dec) begin
            case ({even_in, cv_in, disp_in})
                3'b100:  byte_err = 1'b1;  // coding violation
                3'b111:  byte_err = 1'b1;  // disparity error
                default: byte_err = 1'b0;
            endcase
        end else begin
            byte_err = cv_in | disp_in;
        end
    end
endmodule

// File: rtl/gbe_an_link_timer.sv
module gbe_an_link_timer #(
    parameter int LONG_TICKS  = 1250000,
    parameter int SHORT_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fast,
    output logic expired
);
    localparam int W = $clog2(LONG_TICKS + 1);
    localparam logic [W-1:0] LONG_LIM  = W'(LONG_TICKS - 1);
    localparam logic [W-1:0] SHORT_LIM = W'(SHORT_TICKS - 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] limit;

    always_comb begin
        limit = fast ? SHORT_LIM : LONG_LIM;
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (cnt_q < limit) cnt_d = cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: once expired the timer stays expired until cleared or slowed
    assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> (expired || $fell(fast)));
endmodule

// File: rtl/gbe_an_cfg_rx.sv
module gbe_an_cfg_rx
    import gbe_an_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [7:0]  rx_byte,
    input  logic        rx_is_k,
    input  logic        byte_err,
    output logic        word_vld,
    output logic [15:0] word
);
    typedef struct packed {
        rx_phase_e   phase;
        logic [7:0]  lo;
        logic [15:0] word;
        logic        vld;
    } rx_regs_t;

    rx_regs_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (clr || byte_err) begin
            d.phase = PH_HUNT;
        end else if (rx_is_k && rx_byte == K_COMMA) begin
            d.phase = PH_MARK;
        end else begin
            case (q.phase)
                PH_MARK: d.phase = (!rx_is_k && (rx_byte == D_MARK_A || rx_byte == D_MARK_B))
                                   ? PH_LO : PH_HUNT;
                PH_LO: begin
                    d.phase = rx_is_k ? PH_HUNT : PH_HI;
                    d.lo    = rx_byte;
                end
                PH_HI: begin
                    d.phase = PH_HUNT;
                    if (!rx_is_k) begin
                        d.word = {rx_byte, q.lo};
                        d.vld  = 1'b1;
                    end
                end
                default: d.phase = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_HUNT, lo: '0, word: '0, vld: 1'b0};
        else        q <= d;
    end

    assign word_vld = q.vld;
    assign word     = q.word;

    // R9: an errored byte never completes a word
    assert_err_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_err |=> !word_vld);
endmodule

// File: rtl/gbe_an_ctrl.sv
module gbe_an_ctrl
    import gbe_an_pkg::*;
#(
    parameter int LONG_TICKS  = 1250000,
    parameter int SHORT_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        main_rst,
    input  logic        an_en,
    input  logic        an_restart,
    input  logic        dbg_fast_timer,
    input  logic        sig_ok,
    input  logic [7:0]  rx_byte,
    input  logic        rx_is_k,
    input  logic        err_mode_sel,
    input  logic        rx_even_in,
    input  logic        rx_cv_in,
    input  logic        rx_disp_in,
    input  logic [15:0] local_ability,
    output logic [15:0] tx_cfg_word,
    output logic [15:0] partner_ability,
    output logic        an_busy,
    output logic        page_got,
    output logic        an_done
);
    localparam logic [15:0] ACK_MASK = 16'(1) << ACK_BIT;

    typedef struct packed {
        an_state_e   state;
        logic [15:0] last;
        logic [1:0]  cnt;
        logic [15:0] partner;
    } an_regs_t;

    an_regs_t d, q;
    an_state_e state_q;

    logic        byte_err, word_vld, tmr_exp, tmr_clr;
    logic [15:0] word, word_m;
    logic        ability_match, ack_match, zero_rx, active;

    gbe_an_err_decode u_err (
        .mode_dec (err_mode_sel),
        .even_in  (rx_even_in),
        .cv_in    (rx_cv_in),
        .disp_in  (rx_disp_in),
        .byte_err (byte_err)
    );

    gbe_an_cfg_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (main_rst),
        .rx_byte  (rx_byte),
        .rx_is_k  (rx_is_k),
        .byte_err (byte_err),
        .word_vld (word_vld),
        .word     (word)
    );

    gbe_an_link_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .fast    (dbg_fast_timer),
        .expired (tmr_exp)
    );

    always_comb begin
        word_m        = word & ~ACK_MASK;
        ability_match = word_vld && (word_m != '0) && (word_m == q.last) && (q.cnt >= 2'd2);
        ack_match     = word_vld && word[ACK_BIT] && (word_m == (q.partner & ~ACK_MASK));
        zero_rx       = word_vld && (word == '0);
        active        = (q.state == ST_ABIL) || (q.state == ST_ACK) ||
                        (q.state == ST_CPL)  || (q.state == ST_LINK);

        d = q;
        if (word_vld) begin
            d.last = word_m;
            if (word_m == '0)         d.cnt = 2'd0;
            else if (word_m == q.last) d.cnt = (q.cnt == 2'd3) ? 2'd3 : q.cnt + 2'd1;
            else                      d.cnt = 2'd1;
        end

        case (q.state)
            ST_OFF:     d.state = ST_RESTART;
            ST_RESTART: if (tmr_exp) d.state = ST_ABIL;
            ST_ABIL: if (ability_match) begin
                d.state   = ST_ACK;
                d.partner = word;
            end
            ST_ACK:  if (ack_match) d.state = ST_CPL;
            ST_CPL:  if (tmr_exp)   d.state = ST_LINK;
            default: d.state = q.state;
        endcase

        if (active && zero_rx)     d.state = ST_RESTART;
        if (an_restart || !sig_ok) d.state = ST_RESTART;
        if (!an_en)                d.state = ST_OFF;

        if (d.state == ST_RESTART || d.state == ST_OFF) begin
            d.cnt  = 2'd0;
            d.last = '0;
        end

        if (main_rst) d = '{state: ST_OFF, last: '0, cnt: 2'd0, partner: '0};

        tmr_clr = main_rst || an_restart || (d.state != q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_OFF, last: '0, cnt: 2'd0, partner: '0};
        else        q <= d;
    end

    assign state_q = q.state;

    always_comb begin
        case (q.state)
            ST_ABIL:        tx_cfg_word = local_ability & ~ACK_MASK;
            ST_ACK, ST_CPL: tx_cfg_word = local_ability | ACK_MASK;
            default:        tx_cfg_word = '0;
        endcase
    end

    assign partner_ability = q.partner;
    assign an_busy  = (q.state == ST_RESTART) || (q.state == ST_ABIL) ||
                      (q.state == ST_ACK)     || (q.state == ST_CPL);
    assign page_got = (q.state == ST_CPL);
    assign an_done  = (q.state == ST_LINK);

    // R2: disabled controller is quiet
    assert_en_off_R2: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        !an_en |=> (!an_busy && !an_done));
    // R11: no completion without a receive signal
    assert_sig_loss_R11: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        !sig_ok |=> !an_done);
    // R7: acknowledge-complete is only entered from acknowledge detect
    assert_page_entry_R7: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        $rose(page_got) |-> ($past(state_q) == ST_ACK));
    // R8: completion follows the acknowledge-complete state
    assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        $rose(an_done) |-> $past(page_got));
    // R6: leaving ability detect always leaves a nonzero partner word
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        (state_q == ST_ACK && $past(state_q) == ST_ABIL) |-> (partner_ability != '0));
    // R12: restart request sends the zero word next cycle
    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n || main_rst)
        (an_en && an_restart) |=> (tx_cfg_word == '0));
endmodule

// File: tb/tb_gbe_an_ctrl.sv
`timescale 1ns/1ps
module tb_gbe_an_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_rst = 1'b0, an_en = 1'b0, an_restart = 1'b0;
    logic        dbg_fast_timer = 1'b1, sig_ok = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_is_k = 1'b0, err_mode_sel = 1'b0;
    logic        rx_even_in = 1'b0, rx_cv_in = 1'b0, rx_disp_in = 1'b0;
    logic [15:0] local_ability = 16'h01A0;
    logic [15:0] tx_cfg_word, partner_ability;
    logic        an_busy, page_got, an_done;

    localparam logic [15:0] ACK = 16'h4000;
    localparam logic [15:0] PW  = 16'h0160;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gbe_an_ctrl #(.LONG_TICKS(1250000), .SHORT_TICKS(64)) dut (
        .clk(clk), .rst_n(rst_n), .main_rst(main_rst), .an_en(an_en),
        .an_restart(an_restart), .dbg_fast_timer(dbg_fast_timer), .sig_ok(sig_ok),
        .rx_byte(rx_byte), .rx_is_k(rx_is_k), .err_mode_sel(err_mode_sel),
        .rx_even_in(rx_even_in), .rx_cv_in(rx_cv_in), .rx_disp_in(rx_disp_in),
        .local_ability(local_ability), .tx_cfg_word(tx_cfg_word),
        .partner_ability(partner_ability), .an_busy(an_busy),
        .page_got(page_got), .an_done(an_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b, input logic k, input logic [2:0] e);
        rx_byte = b; rx_is_k = k;
        {rx_even_in, rx_cv_in, rx_disp_in} = e;
        @(negedge clk);
        rx_byte = 8'h00; rx_is_k = 1'b0;
        {rx_even_in, rx_cv_in, rx_disp_in} = 3'b000;
    endtask

    // R5: comma, marker, low byte, high byte; optional error code on the high byte
    task automatic send_cfg(input logic [15:0] w, input logic alt, input logic [2:0] e_hi);
        put(8'hBC, 1'b1, 3'b000);
        put(alt ? 8'h42 : 8'hB5, 1'b0, 3'b000);
        put(w[7:0], 1'b0, 3'b000);
        put(w[15:8], 1'b0, e_hi);
        wait_cyc(3);
    endtask

    task automatic do_restart();
        an_restart = 1'b1; @(negedge clk); an_restart = 1'b0;
        wait_cyc(75);
    endtask

    task automatic t_reset();
        chk("R1 busy", an_busy, 0);
        chk("R1 done", an_done, 0);
        chk("R1 page", page_got, 0);
        chk("R1 partner", partner_ability, 0);
        chk("R1 tx", tx_cfg_word, 0);
    endtask

    task automatic t_disabled();
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        wait_cyc(80);
        chk("R2 busy", an_busy, 0);
        chk("R2 done", an_done, 0);
        chk("R2 tx", tx_cfg_word, 0);
    endtask

    task automatic t_restart_phase();
        an_en = 1'b1;
        wait_cyc(40);
        chk("R3 tx zero in restart", tx_cfg_word, 0);
        chk("R3 busy", an_busy, 1);
        wait_cyc(35);
        chk("R3 R4 ability after short period", tx_cfg_word, local_ability & ~ACK);
    endtask

    task automatic t_negotiate();
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b1, 3'b000);
        chk("R6 two words no match", tx_cfg_word, local_ability & ~ACK);
        send_cfg(PW, 1'b0, 3'b000);
        chk("R6 ack bit sent", tx_cfg_word, local_ability | ACK);
        chk("R5 R6 partner captured", partner_ability, PW);
        chk("R7 no page before ack", page_got, 0);
        send_cfg(PW | ACK, 1'b1, 3'b000);
        chk("R7 page", page_got, 1);
        wait_cyc(30);
        chk("R7 page held", page_got, 1);
        chk("R8 not done yet", an_done, 0);
        wait_cyc(45);
        chk("R8 done", an_done, 1);
        chk("R8 page cleared", page_got, 0);
        chk("R8 busy cleared", an_busy, 0);
        chk("R8 tx idle", tx_cfg_word, 0);
    endtask

    task automatic t_sig_loss();
        sig_ok = 1'b0;
        @(negedge clk);
        chk("R11 done drops", an_done, 0);
        chk("R11 restart word", tx_cfg_word, 0);
        wait_cyc(150);
        chk("R11 held in restart", tx_cfg_word, 0);
        chk("R11 no done", an_done, 0);
        sig_ok = 1'b1;
        wait_cyc(75);
        chk("R11 resumes", tx_cfg_word, local_ability & ~ACK);
    endtask

    task automatic t_restart_input();
        send_cfg(PW, 1'b0, 3'b000);
        an_restart = 1'b1; @(negedge clk); an_restart = 1'b0;
        chk("R12 restart word", tx_cfg_word, 0);
        wait_cyc(40);
        chk("R12 timer restarted", tx_cfg_word, 0);
        wait_cyc(35);
        chk("R12 ability again", tx_cfg_word, local_ability & ~ACK);
    endtask

    // one error case: two good words, a third with code e, then optionally one more good word
    task automatic err_case(input string tag, input logic [2:0] e, input logic dropped);
        do_restart();
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, e);
        chk(tag, tx_cfg_word, dropped ? (local_ability & ~ACK) : (local_ability | ACK));
        if (dropped) begin
            send_cfg(PW, 1'b0, 3'b000);
            chk(tag, tx_cfg_word, local_ability | ACK);
        end
    endtask

    task automatic t_errors();
        err_mode_sel = 1'b1;
        err_case("R9 code100 drops", 3'b100, 1'b1);
        err_case("R9 code111 drops", 3'b111, 1'b1);
        err_case("R9 code011 ignored", 3'b011, 1'b0);
        err_case("R9 code010 ignored", 3'b010, 1'b0);
        err_mode_sel = 1'b0;
        err_case("R10 even ignored", 3'b100, 1'b0);
        err_case("R10 cv drops", 3'b010, 1'b1);
        err_case("R10 disp drops", 3'b001, 1'b1);
    endtask

    task automatic t_zero_rx();
        do_restart();
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        chk("R13 in ack detect", tx_cfg_word, local_ability | ACK);
        send_cfg(16'h0000, 1'b0, 3'b000);
        chk("R13 zero word restarts", tx_cfg_word, 0);
    endtask

    task automatic t_slow_timer();
        dbg_fast_timer = 1'b0;
        an_restart = 1'b1; @(negedge clk); an_restart = 1'b0;
        wait_cyc(200);
        chk("R4 long period not expired", tx_cfg_word, 0);
        dbg_fast_timer = 1'b1;
        wait_cyc(3);
        chk("R4 fast expires at once", tx_cfg_word, local_ability & ~ACK);
    endtask

    task automatic t_main_rst();
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        send_cfg(PW, 1'b0, 3'b000);
        chk("R1 pre-reset partner", partner_ability, PW);
        main_rst = 1'b1; @(negedge clk);
        chk("R1 main reset partner", partner_ability, 0);
        chk("R1 main reset tx", tx_cfg_word, 0);
        chk("R1 main reset busy", an_busy, 0);
        main_rst = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_disabled();
        t_restart_phase();
        t_negotiate();
        t_sig_loss();
        t_restart_input();
        t_errors();
        t_zero_rx();
        t_slow_timer();
        t_main_rst();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule